// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog timer for a small processor subsystem. Software sets two timeout exponents, picks a mode, and then must write a fixed key value at regular intervals to restart the countdown. If the countdown runs out, the block asks the system for a reset.

There are two modes. In reset-only mode a single countdown ends directly in a one-cycle reset request. In interrupt mode the first countdown raises an interrupt instead and a second countdown starts. If software services the interrupt before the second countdown ends, the watchdog starts over at the first stage. If it does not, the reset request is issued. Each stage lasts a power of two of clock cycles, 2^(8+i), where i is a 4-bit exponent.

The register bus is a plain single-cycle port. Writes take effect at the clock edge where the write enable is high. Read data is combinational from the address. The read strobe is used only for the side effect of the end-of-interrupt register.

Top module: `wdog_two_stage`

## Requirements
- R1: While the enable bit (bit 0 of the control register, word address 0) is 0, the live count holds its value and neither the interrupt nor the reset request is raised.
- R2: Control bit 1 selects the mode: 1 is interrupt-then-reset, 0 is reset-only. The interrupt can rise only in interrupt mode.
- R3: The range register (word address 1) holds the first-stage exponent in bits 7:4 and the second-stage exponent in bits 3:0. A stage with exponent i loads 2^(8+i) and then decrements once per enabled cycle. It expires on the cycle after the count reads zero, so a stage spans load+1 cycles.
- R4: In reset-only mode, the reset request pulses load1+1 cycles after the count is loaded with the first-stage value. The count then reloads the first-stage value and repeats. The second-stage field has no effect and no interrupt is raised.
- R5: In interrupt mode, when the first stage expires the interrupt goes high and the second-stage value is loaded. If the second stage expires with the interrupt still pending, the reset request pulses load2+1 cycles after the interrupt rose.
- R6: If the pending interrupt was cleared before the second stage expires, no reset is requested. The count reloads the first-stage value and the first stage runs again.
- R7: Writing exactly 0x76 to the restart register (word address 2) reloads the first-stage value, returns the block to the first stage and clears any pending interrupt. It does this even while counting is disabled.
- R8: Writing any other value to the restart register has no effect on the count or the timing.
- R9: Bit 0 of the status register (word address 3) and the interrupt output are both 1 exactly while an interrupt is pending.
- R10: Reading the end-of-interrupt register (word address 4, read strobe high) clears the pending interrupt at that clock edge.
- R11: The count register (word address 5) returns the full live counter value. After reset, control, range and status read 0 and the count reads 256.
- R12: Each reset request is a single-cycle pulse. The same edge clears any pending interrupt and reloads the first-stage value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | DATA_W | Write data |
| bus_rd_en | input | 1 | Read strobe (used for end-of-interrupt side effect) |
| bus_rd_data | output | DATA_W | Combinational read data for bus_addr |
| wdt_irq | output | 1 | Watchdog interrupt, level, high while pending |
| wdt_sysrst_req | output | 1 | One-cycle system reset request |

## Verification
The hardest case to reach is a serviced interrupt. The end-of-interrupt read has to land inside the second-stage window after the interrupt rose, and the bench must then show that the stage-two expiry passes silently and that the first stage restarts with exact timing. The stimulus uses exponents of 1 and 0, which give 512- and 256-cycle stages. It times the end-of-interrupt read from the recorded restart cycle and predicts every later interrupt and reset edge in absolute cycles. It also places a restart write in the middle of a second stage, to show that the block falls back to the first stage rather than continuing to the pending reset.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int EXP_BASE = 8;
    localparam int FIELD_W  = 4;
    localparam int CNT_W    = EXP_BASE + (1 << FIELD_W);
    localparam logic [7:0] RESTART_KEY = 8'h76;

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_RANGE = 3'd1,
        A_KICK  = 3'd2,
        A_STAT  = 3'd3,
        A_EOI   = 3'd4,
        A_COUNT = 3'd5
    } reg_addr_e;

    typedef enum logic {
        ST_FIRST  = 1'b0,
        ST_SECOND = 1'b1
    } stage_e;

    typedef struct packed {
        logic mode_irq;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic [FIELD_W-1:0] first;
        logic [FIELD_W-1:0] second;
    } range_t;

    typedef struct packed {
        logic kick;
        logic eoi;
    } cmd_t;

    function automatic logic [CNT_W-1:0] exp_to_load(input logic [FIELD_W-1:0] e);
        return CNT_W'(1) << (EXP_BASE + int'(e));
    endfunction

endpackage

// File: rtl/wdg_regfile.sv
module wdg_regfile
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              pending_i,
    input  logic [CNT_W-1:0]  count_i,
    output ctrl_t             ctrl_o,
    output range_t            range_o,
    output cmd_t              cmd_o,
    output logic [DATA_W-1:0] rd_data
);

    localparam int CTRL_W  = $bits(ctrl_t);
    localparam int RANGE_W = $bits(range_t);

    ctrl_t  ctrl_q;
    range_t range_q;

    wire sel_ctrl  = (addr == ADDR_W'(A_CTRL));
    wire sel_range = (addr == ADDR_W'(A_RANGE));
    wire sel_kick  = (addr == ADDR_W'(A_KICK));
    wire sel_stat  = (addr == ADDR_W'(A_STAT));
    wire sel_eoi   = (addr == ADDR_W'(A_EOI));
    wire sel_count = (addr == ADDR_W'(A_COUNT));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            range_q <= '0;
        end else if (wr_en) begin
            if (sel_ctrl)
                ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (sel_range)
                range_q <= range_t'(wr_data[RANGE_W-1:0]);
        end
    end

    always_comb begin
        cmd_o.kick = wr_en && sel_kick && (wr_data == DATA_W'(RESTART_KEY));
        cmd_o.eoi  = rd_en && sel_eoi;
    end

    always_comb begin
        rd_data = '0;
        if (sel_ctrl)  rd_data = DATA_W'(ctrl_q);
        if (sel_range) rd_data = DATA_W'(range_q);
        if (sel_stat)  rd_data = DATA_W'(pending_i);
        if (sel_count) rd_data = DATA_W'(count_i);
    end

    assign ctrl_o  = ctrl_q;
    assign range_o = range_q;

endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl_i,
    input  range_t           range_i,
    input  cmd_t             cmd_i,
    output logic [CNT_W-1:0] count_o,
    output logic             pending_o,
    output logic             sysrst_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_first;
    logic [CNT_W-1:0] load_second;
    stage_e           stage_q;
    logic             pend_q;
    logic             pulse_q;

    assign load_first  = exp_to_load(range_i.first);
    assign load_second = exp_to_load(range_i.second);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= exp_to_load('0);
            stage_q <= ST_FIRST;
            pend_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (cmd_i.eoi)
                pend_q <= 1'b0;
            if (cmd_i.kick) begin
                cnt_q   <= load_first;
                stage_q <= ST_FIRST;
                pend_q  <= 1'b0;
            end else if (ctrl_i.enable) begin
                if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end else if (stage_q == ST_FIRST && ctrl_i.mode_irq) begin
                    pend_q  <= ~cmd_i.eoi;
                    cnt_q   <= load_second;
                    stage_q <= ST_SECOND;
                end else if (stage_q == ST_SECOND && !pend_q) begin
                    cnt_q   <= load_first;
                    stage_q <= ST_FIRST;
                end else begin
                    pulse_q <= 1'b1;
                    pend_q  <= 1'b0;
                    cnt_q   <= load_first;
                    stage_q <= ST_FIRST;
                end
            end
        end
    end

    assign count_o   = cnt_q;
    assign pending_o = pend_q;
    assign sysrst_o  = pulse_q;

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wr_data,
    input  logic              bus_rd_en,
    output logic [DATA_W-1:0] bus_rd_data,
    output logic              wdt_irq,
    output logic              wdt_sysrst_req
);

    ctrl_t            ctrl_w;
    range_t           range_w;
    cmd_t             cmd_w;
    logic [CNT_W-1:0] count_w;
    logic             pending_w;

    wdg_regfile #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .wr_en    (bus_wr_en),
        .wr_data  (bus_wr_data),
        .rd_en    (bus_rd_en),
        .pending_i(pending_w),
        .count_i  (count_w),
        .ctrl_o   (ctrl_w),
        .range_o  (range_w),
        .cmd_o    (cmd_w),
        .rd_data  (bus_rd_data)
    );

    wdg_countdown u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ctrl_i   (ctrl_w),
        .range_i  (range_w),
        .cmd_i    (cmd_w),
        .count_o  (count_w),
        .pending_o(pending_w),
        .sysrst_o (wdt_sysrst_req)
    );

    assign wdt_irq = pending_w;

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic              irq,
    input logic              sysrst,
    input ctrl_t             ctrl,
    input logic [CNT_W-1:0]  cnt
);

    wire kick_w = wr_en && (addr == ADDR_W'(A_KICK)) && (wr_data == DATA_W'(RESTART_KEY));
    wire eoi_w  = rd_en && (addr == ADDR_W'(A_EOI));

    // R1: no events while disabled
    p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (rst)
        !ctrl.enable |=> (!sysrst && !$rose(irq)))
        else $error("p_quiet_when_off_r1");

    // R1: count frozen while disabled
    p_hold_when_off_r1: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.enable && !kick_w) |=> $stable(cnt))
        else $error("p_hold_when_off_r1");

    // R2: interrupt rises only in interrupt mode
    p_irq_mode_only_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(ctrl.mode_irq))
        else $error("p_irq_mode_only_r2");

    // R3: one decrement per enabled cycle
    p_count_down_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl.enable && cnt != '0 && !kick_w) |=> (cnt == CNT_W'($past(cnt) - 1'b1)))
        else $error("p_count_down_r3");

    // R4: reset request only after the count reached zero
    p_reset_from_zero_r4: assert property (@(posedge clk) disable iff (rst)
        sysrst |-> ($past(cnt) == '0))
        else $error("p_reset_from_zero_r4");

    // R7: restart key clears the interrupt
    p_kick_clears_r7: assert property (@(posedge clk) disable iff (rst)
        kick_w |=> !irq)
        else $error("p_kick_clears_r7");

    // R10: end-of-interrupt read clears the interrupt
    p_eoi_clears_r10: assert property (@(posedge clk) disable iff (rst)
        eoi_w |=> !irq)
        else $error("p_eoi_clears_r10");

    // R12: reset request lasts one cycle
    p_single_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        sysrst |=> !sysrst)
        else $error("p_single_pulse_r12");

endmodule

bind wdog_two_stage wdg_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .addr   (bus_addr),
    .wr_en  (bus_wr_en),
    .wr_data(bus_wr_data),
    .rd_en  (bus_rd_en),
    .irq    (wdt_irq),
    .sysrst (wdt_sysrst_req),
    .ctrl   (ctrl_w),
    .cnt    (count_w)
);

// File: tb/sim_wdog_two_stage.sv
module sim_wdog_two_stage;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;
    localparam int EV_IRQ = 1;
    localparam int EV_RST = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr_en = 1'b0;
    logic [DATA_W-1:0] bus_wr_data = '0;
    logic              bus_rd_en = 1'b0;
    logic [DATA_W-1:0] bus_rd_data;
    logic              wdt_irq;
    logic              wdt_sysrst_req;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    logic irq_d = 1'b0;
    logic finished = 1'b0;

    typedef struct {
        int    kind;
        int    at;
        string req;
    } ev_t;
    ev_t exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_two_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
        .clk           (clk),
        .rst           (rst),
        .bus_addr      (bus_addr),
        .bus_wr_en     (bus_wr_en),
        .bus_wr_data   (bus_wr_data),
        .bus_rd_en     (bus_rd_en),
        .bus_rd_data   (bus_rd_data),
        .wdt_irq       (wdt_irq),
        .wdt_sysrst_req(wdt_sysrst_req)
    );

    task automatic check(input string req, input string what, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    task automatic push_ev(input int kind, input int at, input string req);
        ev_t e;
        e.kind = kind;
        e.at   = at;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    task automatic got_ev(input int kind);
        ev_t e;
        n_cmp++;
        if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected event: actual kind %0d at %0d expected none", kind, cyc);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != kind || e.at != cyc) begin
                n_bad++;
                $display("FAIL %s event: actual kind %0d at %0d expected kind %0d at %0d",
                         e.req, kind, cyc, e.kind, e.at);
            end
        end
    endtask

    // monitor: compares observed edges against the scoreboard queue
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (wdt_irq && !irq_d) got_ev(EV_IRQ);
            if (wdt_sysrst_req)    got_ev(EV_RST);
        end
        irq_d = wdt_irq;
    end

    task automatic wr(input int a, input int d, output int w);
        bus_addr    = ADDR_W'(a);
        bus_wr_data = DATA_W'(d);
        bus_wr_en   = 1'b1;
        @(negedge clk);
        bus_wr_en   = 1'b0;
        w = cyc;
    endtask

    task automatic rd(input int a, output int d, output int at);
        bus_addr  = ADDR_W'(a);
        bus_rd_en = 1'b1;
        #1;
        d  = int'(bus_rd_data);
        at = cyc;
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic summary;
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int w, w2, d, at;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11: reset state
        rd(0, d, at); check("R11", "ctrl after reset", d, 0);
        rd(1, d, at); check("R11", "range after reset", d, 0);
        rd(3, d, at); check("R11", "status after reset", d, 0);
        rd(5, d, at); check("R11", "count after reset", d, 256);
        check("R11", "irq after reset", int'(wdt_irq), 0);
        check("R11", "sysrst after reset", int'(wdt_sysrst_req), 0);

        // R1: disabled block holds its count
        wr(1, 'h13, w);
        repeat (400) @(negedge clk);
        rd(5, d, at); check("R1", "count frozen while disabled", d, 256);
        // R7: key reloads even when disabled
        wr(2, 'h76, w);
        repeat (50) @(negedge clk);
        rd(5, d, at); check("R7", "kick loads first stage while disabled", d, 512);

        // R4/R3/R8: reset-only mode, first 512, second field 3 must be ignored
        wr(0, 1, w);
        wr(2, 'h76, w);
        push_ev(EV_RST, w + 513, "R4");
        push_ev(EV_RST, w + 1026, "R4");
        wait_until(w + 10);
        rd(5, d, at); check("R11", "live count", d, 512 - (at - w));
        wait_until(w + 100);
        wr(2, 'h77, w2);
        rd(5, d, at); check("R8", "wrong key ignored", d, 512 - (at - w));
        wait_until(w + 600);
        rd(3, d, at); check("R4", "no interrupt in reset-only mode", d, 0);
        wait_until(w + 1031);
        wr(0, 0, w2);
        repeat (700) @(negedge clk);
        check("R4", "reset-only events consumed", exp_q.size(), 0);

        // R5/R9/R10/R6/R12: interrupt mode, first 512, second 256
        wr(1, 'h10, w2);
        wr(0, 3, w2);
        wr(2, 'h76, w);
        push_ev(EV_IRQ, w + 513, "R5");
        push_ev(EV_RST, w + 770, "R5");
        push_ev(EV_IRQ, w + 1283, "R12");
        wait_until(w + 520);
        rd(3, d, at); check("R9", "status while pending", d, 1);
        check("R9", "irq while pending", int'(wdt_irq), 1);
        wait_until(w + 772);
        check("R12", "irq cleared by reset pulse", int'(wdt_irq), 0);
        check("R12", "sysrst single cycle", int'(wdt_sysrst_req), 0);
        wait_until(w + 1290);
        rd(4, d, at);
        check("R10", "irq after end-of-interrupt read", int'(wdt_irq), 0);
        rd(3, d, at); check("R10", "status after end-of-interrupt read", d, 0);
        push_ev(EV_IRQ, w + 2053, "R6");
        wait_until(w + 2060);
        check("R6", "irq after serviced restart", int'(wdt_irq), 1);
        wr(2, 'h76, w2);
        check("R7", "irq cleared by key", int'(wdt_irq), 0);
        rd(5, d, at); check("R7", "count reloaded by key", d, 512 - (at - w2));
        push_ev(EV_IRQ, w2 + 513, "R7");
        wait_until(w2 + 530);
        wr(0, 0, w);
        repeat (800) @(negedge clk);
        check("R5", "interrupt-mode events consumed", exp_q.size(), 0);

        summary();
    end

endmodule